// File: doc/BRIEF.md
# Two-Wire Write Receiver for a 16-bit Converter

This block is the serial front end of a single-channel 16-bit digital-to-analog converter. It listens on a two-wire I2C bus and takes write transactions only. SCL and SDA come in as sampled line levels. The block pulls SDA low through a separate output enable, which the pad turns into an open-drain driver.

A transaction runs in this order:
- A START condition.
- A 7-bit address with R/W = 0. The address is a fixed pattern whose lowest bit comes from a strap pin.
- One control byte.
- Any number of high/low byte pairs.

The control byte decides how every pair in the transaction is read. A pair is either a new 16-bit converter code or a power-down command. It also sets the load and broadcast-select flags that go with each update.

Each completed pair produces a one-cycle update strobe. The strobe comes with the 16-bit word, a power-down flag and the control flags. Downstream converter logic registers these on the strobe.

Top module: `dacwr_i2c_slave`

## Requirements
- R1: An address byte equal to 1,0,0,1,1,0,`addr_sel` (MSB first) followed by R/W = 0 is acknowledged. The block holds SDA low (`sda_oe` = 1) during the ninth SCL pulse.
- R2: An address byte that differs in any of its seven address bits, or that has R/W = 1, is not acknowledged. After it, no byte is acknowledged and no update strobe occurs until the next START.
- R3: The control byte is acknowledged. Its bit 7 is Load1 (`upd_load1`), bit 6 is Load0 (`upd_load0`), bit 4 is broadcast select (`upd_bcast`) and bit 0 chooses power-down interpretation. These flags are reported with each update.
- R4: With control bit 0 clear, a high byte then a low byte, each MSB first, produce `upd_word` = {high, low} and `upd_is_pd` = 0.
- R5: With control bit 0 set, a byte pair is a power-down command. `upd_is_pd` = 1 and `upd_word` holds the pair as received, with the mode bits in bits 15:14.
- R6: Every data byte of an addressed transaction is acknowledged.
- R7: Further pairs in the same transaction each produce an update under the same control byte.
- R8: `upd_strobe` is high for exactly one clock per completed pair. The word and flag outputs change only together with the strobe.
- R9: A high byte that has no low byte before STOP is discarded: no strobe occurs.
- R10: A repeated START returns the block to address matching. The next accepted control byte governs the pairs that follow it.
- R11: After reset `sda_oe`, `upd_strobe`, `upd_word` and all flags are 0.
- R12: `sda_oe` changes only while the synchronised SCL is low, except when a START or STOP clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| addr_sel | input | 1 | Strap for the lowest address bit |
| upd_strobe | output | 1 | One-cycle pulse per completed pair |
| upd_word | output | 16 | Word of the last completed pair |
| upd_is_pd | output | 1 | 1 if the last pair was a power-down command |
| upd_load1 | output | 1 | Load1 flag of the control byte |
| upd_load0 | output | 1 | Load0 flag of the control byte |
| upd_bcast | output | 1 | Broadcast-select flag of the control byte |

## Verification
The assertions check four things on every cycle:
- The update strobe never lasts more than one cycle.
- The output word changes only with a strobe.
- The acknowledge enable stays off while the receiver is ignoring a foreign transaction.
- The enable moves only while SCL is low, apart from START and STOP.

The bench scenarios cover the behaviour that depends on byte content and sequence:
- Address matching against the strap pin.
- The R/W rejection.
- Decoding of the control flags.
- Data versus power-down words.
- Repeated pairs.
- A lone high byte discarded at STOP.
- A repeated START switching to a new control byte.

// File: rtl/dacwr_pkg.sv
package dacwr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CTRL,
        PH_HIGH,
        PH_LOW,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic load1;
        logic load0;
        logic bcast;
        logic pd_sel;
    } ctrl_t;

endpackage

// File: rtl/dacwr_bus_front.sv
module dacwr_bus_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    localparam int NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    typedef struct packed {
        logic [NS-1:0] scl_ch;
        logic [NS-1:0] sda_ch;
        logic          scl_p;
        logic          sda_p;
    } front_t;

    front_t q, d;

    always_comb begin
        d        = q;
        d.scl_ch = {q.scl_ch[NS-2:0], scl_i};
        d.sda_ch = {q.sda_ch[NS-2:0], sda_i};
        d.scl_p  = q.scl_ch[NS-1];
        d.sda_p  = q.sda_ch[NS-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl_ch: '1, sda_ch: '1, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign scl_lvl   = q.scl_ch[NS-1];
    assign sda_lvl   = q.sda_ch[NS-1];
    assign scl_rise  = scl_lvl & ~q.scl_p;
    assign scl_fall  = ~scl_lvl & q.scl_p;
    // SDA edges while SCL stays high are bus conditions
    assign bus_start = scl_lvl & q.scl_p & q.sda_p & ~sda_lvl;
    assign bus_stop  = scl_lvl & q.scl_p & ~q.sda_p & sda_lvl;

endmodule

// File: rtl/dacwr_byte_rx.sv
module dacwr_byte_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              ack_req,
    output logic [BYTE_W-1:0] byte_val,
    output logic              byte_done,
    output logic              sda_oe
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              in_ack;
        logic              oe;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d         = q;
        byte_done = 1'b0;
        if (bus_start || bus_stop) begin
            d.cnt    = '0;
            d.in_ack = 1'b0;
            d.oe     = 1'b0;
        end else if (scl_rise && !q.in_ack && (q.cnt < FULL)) begin
            d.shreg = {q.shreg[BYTE_W-2:0], sda_lvl};
            d.cnt   = q.cnt + 1'b1;
        end else if (scl_fall) begin
            if (q.in_ack) begin
                // ninth pulse over: release and start next byte
                d.in_ack = 1'b0;
                d.oe     = 1'b0;
                d.cnt    = '0;
            end else if (q.cnt == FULL) begin
                byte_done = 1'b1;
                d.in_ack  = 1'b1;
                d.oe      = ack_req;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign byte_val = q.shreg;
    assign sda_oe   = q.oe;

endmodule

// File: rtl/dacwr_decode.sv
module dacwr_decode
    import dacwr_pkg::*;
#(
    parameter int          BYTE_W  = 8,
    parameter logic [5:0]  ADDR_HI = 6'b100110
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_sel,
    input  logic                bus_start,
    input  logic                bus_stop,
    input  logic                byte_done,
    input  logic [BYTE_W-1:0]   byte_val,
    output logic                ack_req,
    output logic                in_skip,
    output logic                upd_strobe,
    output logic [2*BYTE_W-1:0] upd_word,
    output logic                upd_is_pd,
    output logic                upd_load1,
    output logic                upd_load0,
    output logic                upd_bcast
);

    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        phase_e            phase;
        ctrl_t             ctrl;
        logic [BYTE_W-1:0] hi;
        logic [WORD_W-1:0] word;
        ctrl_t             out_ctrl;
        logic              strobe;
    } dec_t;

    dec_t q, d;
    logic addr_hit;

    assign addr_hit = (byte_val == {ADDR_HI, addr_sel, 1'b0});

    always_comb begin
        case (q.phase)
            PH_ADDR:                  ack_req = addr_hit;
            PH_CTRL, PH_HIGH, PH_LOW: ack_req = 1'b1;
            default:                  ack_req = 1'b0;
        endcase
    end

    always_comb begin
        d        = q;
        d.strobe = 1'b0;
        if (bus_start) begin
            d.phase = PH_ADDR;
        end else if (bus_stop) begin
            d.phase = PH_IDLE;
        end else if (byte_done) begin
            case (q.phase)
                PH_ADDR: d.phase = addr_hit ? PH_CTRL : PH_SKIP;
                PH_CTRL: begin
                    d.ctrl  = '{load1:  byte_val[7], load0: byte_val[6],
                                bcast:  byte_val[4], pd_sel: byte_val[0]};
                    d.phase = PH_HIGH;
                end
                PH_HIGH: begin
                    d.hi    = byte_val;
                    d.phase = PH_LOW;
                end
                PH_LOW: begin
                    d.word     = {q.hi, byte_val};
                    d.out_ctrl = q.ctrl;
                    d.strobe   = 1'b1;
                    d.phase    = PH_HIGH;
                end
                default: d.phase = q.phase;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign in_skip    = (q.phase == PH_SKIP);
    assign upd_strobe = q.strobe;
    assign upd_word   = q.word;
    assign upd_is_pd  = q.out_ctrl.pd_sel;
    assign upd_load1  = q.out_ctrl.load1;
    assign upd_load0  = q.out_ctrl.load0;
    assign upd_bcast  = q.out_ctrl.bcast;

endmodule

// File: rtl/dacwr_i2c_slave.sv
module dacwr_i2c_slave #(
    parameter int         SYNC_STAGES = 2,
    parameter int         BYTE_W      = 8,
    parameter logic [5:0] ADDR_HI     = 6'b100110
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    input  logic                addr_sel,
    output logic                upd_strobe,
    output logic [2*BYTE_W-1:0] upd_word,
    output logic                upd_is_pd,
    output logic                upd_load1,
    output logic                upd_load0,
    output logic                upd_bcast
);

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall;
    logic              bus_start, bus_stop;
    logic              ack_req, byte_done, in_skip;
    logic [BYTE_W-1:0] byte_val;

    dacwr_bus_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    dacwr_byte_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop),
        .ack_req  (ack_req),
        .byte_val (byte_val),
        .byte_done(byte_done),
        .sda_oe   (sda_oe)
    );

    dacwr_decode #(.BYTE_W(BYTE_W), .ADDR_HI(ADDR_HI)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_sel  (addr_sel),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .ack_req   (ack_req),
        .in_skip   (in_skip),
        .upd_strobe(upd_strobe),
        .upd_word  (upd_word),
        .upd_is_pd (upd_is_pd),
        .upd_load1 (upd_load1),
        .upd_load0 (upd_load0),
        .upd_bcast (upd_bcast)
    );

endmodule

// File: rtl/dacwr_checker.sv
module dacwr_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              bus_start,
    input logic              bus_stop,
    input logic              in_skip,
    input logic              sda_oe,
    input logic              upd_strobe,
    input logic [WORD_W-1:0] upd_word
);

    // R8: strobe lasts one cycle
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |=> !upd_strobe);

    // R8: word moves only together with the strobe
    a_r8_word_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(upd_word) |-> upd_strobe);

    // R2: a rejected transaction is never acknowledged
    a_r2_no_ack_while_skipping: assert property (@(posedge clk) disable iff (!rst_n)
        in_skip |-> !sda_oe);

    // R12: acknowledge enable changes only with SCL low or on a bus condition
    a_r12_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!$past(scl_lvl) || $past(bus_start) || $past(bus_stop)));

endmodule

bind dacwr_i2c_slave dacwr_checker #(.WORD_W(2*BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .in_skip   (in_skip),
    .sda_oe    (sda_oe),
    .upd_strobe(upd_strobe),
    .upd_word  (upd_word)
);

// File: tb/dacwr_i2c_slave_bench.sv
module dacwr_i2c_slave_bench;

    localparam int Q = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1, a0 = 1'b0;
    logic        sda_oe, upd_strobe, upd_is_pd, upd_load1, upd_load0, upd_bcast;
    logic [15:0] upd_word;
    wire         sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    dacwr_i2c_slave u_dacwr_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_sel(a0), .upd_strobe(upd_strobe),
        .upd_word(upd_word), .upd_is_pd(upd_is_pd), .upd_load1(upd_load1),
        .upd_load0(upd_load0), .upd_bcast(upd_bcast)
    );

    int tests = 0, fails = 0, stb_cnt = 0, dbl_cnt = 0;
    bit finished = 0;
    logic prev_stb = 1'b0;

    always @(negedge clk) begin
        if (upd_strobe) stb_cnt++;
        if (upd_strobe && prev_stb) dbl_cnt++;
        prev_stb = upd_strobe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start_c();
        sda_m = 1'b1; waitq(Q); scl_m = 1'b1; waitq(Q);
        sda_m = 1'b0; waitq(Q); scl_m = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop_c();
        sda_m = 1'b0; waitq(Q); scl_m = 1'b1; waitq(Q);
        sda_m = 1'b1; waitq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; waitq(Q); scl_m = 1'b1; waitq(Q); scl_m = 1'b0; waitq(Q);
        end
        sda_m = 1'b1; waitq(Q); scl_m = 1'b1; waitq(Q / 2);
        acked = !sda_line;
        waitq(Q / 2); scl_m = 1'b0; waitq(Q);
    endtask

    typedef struct packed {
        logic       a0;
        logic [7:0] addr;
        logic [7:0] ctrl;
        logic [7:0] hi;
        logic [7:0] lo;
        logic       ack;
        logic       pd;
        logic [1:0] load;
        logic       bc;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 8'h98, 8'h00, 8'h12, 8'h34, 1'b1, 1'b0, 2'b00, 1'b0},
        '{1'b1, 8'h9A, 8'hD0, 8'hAB, 8'hCD, 1'b1, 1'b0, 2'b11, 1'b1},
        '{1'b1, 8'h98, 8'h00, 8'h55, 8'h66, 1'b0, 1'b0, 2'b00, 1'b0},
        '{1'b0, 8'h99, 8'h00, 8'h77, 8'h88, 1'b0, 1'b0, 2'b00, 1'b0},
        '{1'b0, 8'h98, 8'h01, 8'hC0, 8'h00, 1'b1, 1'b1, 2'b00, 1'b0},
        '{1'b0, 8'h18, 8'h00, 8'h11, 8'h22, 1'b0, 1'b0, 2'b00, 1'b0},
        '{1'b1, 8'h9A, 8'h80, 8'hFF, 8'h00, 1'b1, 1'b0, 2'b10, 1'b0}
    };

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog R1 actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit ak;
        int base;
        repeat (4) @(negedge clk);
        // R11: reset state
        check(sda_oe == 0 && upd_strobe == 0, "R11 oe/strobe", {sda_oe, upd_strobe}, 0);
        check(upd_word == 0 && {upd_is_pd, upd_load1, upd_load0, upd_bcast} == 0,
              "R11 outputs", upd_word, 0);
        rst_n = 1'b1;
        waitq(10);

        foreach (VECS[k]) begin
            a0 = VECS[k].a0;
            base = stb_cnt;
            bus_start_c();
            send_byte(VECS[k].addr, ak);
            check(ak == VECS[k].ack, VECS[k].ack ? "R1 address ack" : "R2 address nack", ak, VECS[k].ack);
            send_byte(VECS[k].ctrl, ak);
            check(ak == VECS[k].ack, "R3 control ack", ak, VECS[k].ack);
            send_byte(VECS[k].hi, ak);
            check(ak == VECS[k].ack, "R6 high ack", ak, VECS[k].ack);
            send_byte(VECS[k].lo, ak);
            check(ak == VECS[k].ack, "R6 low ack", ak, VECS[k].ack);
            bus_stop_c();
            check(stb_cnt - base == int'(VECS[k].ack), "R8 strobe count", stb_cnt - base, VECS[k].ack);
            if (VECS[k].ack) begin
                check(upd_word == {VECS[k].hi, VECS[k].lo}, "R4 word", upd_word, {VECS[k].hi, VECS[k].lo});
                check(upd_is_pd == VECS[k].pd, "R5 pd flag", upd_is_pd, VECS[k].pd);
                check({upd_load1, upd_load0, upd_bcast} == {VECS[k].load, VECS[k].bc},
                      "R3 control flags", {upd_load1, upd_load0, upd_bcast}, {VECS[k].load, VECS[k].bc});
            end
        end

        // R7: three pairs under one control byte (Load0 set)
        a0 = 1'b0; base = stb_cnt;
        bus_start_c();
        send_byte(8'h98, ak); send_byte(8'h40, ak);
        for (int p = 0; p < 3; p++) begin
            send_byte(8'h10 + 8'(p), ak);
            check(ak, "R6 repeat high ack", ak, 1);
            send_byte(8'hA0 + 8'(p), ak);
            check(upd_word == {8'h10 + 8'(p), 8'hA0 + 8'(p)} && upd_load0 && !upd_load1,
                  "R7 pair word", upd_word, {8'h10 + 8'(p), 8'hA0 + 8'(p)});
        end
        // R9: lone high byte then STOP
        send_byte(8'h5A, ak);
        bus_stop_c();
        check(stb_cnt - base == 3, "R9 lone byte discarded", stb_cnt - base, 3);
        check(upd_word == 16'h12A2, "R9 word unchanged", upd_word, 16'h12A2);

        // R10: repeated START changes control byte
        base = stb_cnt;
        bus_start_c();
        send_byte(8'h98, ak); send_byte(8'h00, ak);
        send_byte(8'h01, ak); send_byte(8'h02, ak);
        check(upd_word == 16'h0102 && !upd_is_pd, "R10 first segment", upd_word, 16'h0102);
        bus_start_c();
        send_byte(8'h98, ak);
        check(ak, "R10 readdress ack", ak, 1);
        send_byte(8'h01, ak); send_byte(8'h40, ak); send_byte(8'h00, ak);
        check(upd_word == 16'h4000 && upd_is_pd, "R10 new control pd", upd_word, 16'h4000);
        // R2/R10: repeated START to a foreign address ignores the pair
        bus_start_c();
        send_byte(8'h9A, ak);
        check(!ak, "R2 foreign readdress nack", ak, 0);
        send_byte(8'h33, ak); send_byte(8'h44, ak);
        check(!ak, "R2 skipped byte nack", ak, 0);
        bus_stop_c();
        check(stb_cnt - base == 2, "R2 no strobe while skipping", stb_cnt - base, 2);
        check(upd_word == 16'h4000, "R2 word held", upd_word, 16'h4000);

        check(dbl_cnt == 0, "R8 strobe width", dbl_cnt, 0);
        // R12: bus idle leaves SDA released
        check(sda_oe == 0, "R12 released at idle", sda_oe, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule